// File: doc/BRIEF.md
# Carrier Detect Qualification Timer

This block turns the raw one-bit "energy present" flag of a tone or carrier detector into a debounced, active-low carrier-detect output. A detector outside the block raises the flag. The block declares carrier only after the flag has stayed high for a qualification time, and withdraws carrier only after the flag has stayed low for a release time. Both times are counted in millisecond ticks. They depend on the operating mode (FSK, DTMF or call-progress) and, for FSK and DTMF, on a 2-bit delay select.

Carrier detect also gates the data paths. While no carrier is qualified, the demodulated data bit is held at mark (1) and the 4-bit DTMF digit output is held at zero. In either power-down state the block clears its qualification and drops the enable of the digit output pads.

By default the tick input is the 1 ms enable itself. A parameter can instead insert a prescaler that counts a faster base enable down to the millisecond rate.

Top module: `cdq_timer`

## Requirements
- R1: After reset, cd_n is 1, rxd_out is 1 and dig_out is 4'b0000.
- R2: In FSK mode (mode 2'b00), cd_n falls on the clock edge that counts the Nth consecutive tick with raw_det high. N is 450, 15, 15 or 75 for fsk_sel 2'b00, 2'b01, 2'b10, 2'b11.
- R3: In FSK mode, a qualified carrier is released (cd_n rises) on the edge that counts the Mth consecutive tick with raw_det low. M is 30, 30, 15 or 10 for fsk_sel 2'b00, 2'b01, 2'b10, 2'b11.
- R4: In DTMF mode (mode 2'b01), the qualify/release counts are 30/25, 35/35 and 45/25 for dtmf_sel 2'b00, 2'b01, 2'b10. dtmf_sel 2'b11 uses the same counts as 2'b00.
- R5: In call-progress mode (mode 2'b10), the qualify/release counts are 10/25, whatever either select holds.
- R6: Any clock in which raw_det has the value opposite to the pending transition restarts the count from zero. A clock in which tick_ms is 0 does not advance the count.
- R7: While cd_n is 1, rxd_out is 1. While cd_n is 0, rxd_out equals rx_bit.
- R8: dig_out equals dtmf_code (bit 0 the least significant) only while mode is DTMF and cd_n is 0. At all other times it is 4'b0000.
- R9: While pd1 or pd2 is 1, dig_en is 0. On the next edge cd_n is 1 and the count is cleared. Counting restarts from zero once both flags are 0.
- R10: In idle mode (mode 2'b11), cd_n is 1 from the next edge on, whatever raw_det does.
- R11: A change of mode drops cd_n to 1 on the next edge, and qualification then starts from zero under the new mode's counts.
- R12: With TICK_DIV greater than 1, one counted tick occurs for every TICK_DIV pulses of tick_ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | Millisecond tick enable (base enable when TICK_DIV > 1) |
| raw_det | input | 1 | Raw energy-present flag from the active detector |
| mode | input | 2 | 00 FSK, 01 DTMF, 10 call-progress, 11 idle |
| fsk_sel | input | 2 | FSK delay select |
| dtmf_sel | input | 2 | DTMF delay select |
| rx_bit | input | 1 | Demodulated FSK data bit |
| dtmf_code | input | 4 | Decoded DTMF digit code |
| pd1 | input | 1 | Power-down state 1 flag |
| pd2 | input | 1 | Power-down state 2 flag |
| cd_n | output | 1 | Qualified carrier detect, active low |
| rxd_out | output | 1 | Received data, held at 1 without carrier |
| dig_out | output | 4 | Gated DTMF digit |
| dig_en | output | 1 | Output enable for the digit pads |

## Verification
The bench walks every select value of each mode and probes the edge just before and the edge of each transition. A timer that is off by one tick, or that reads the wrong table entry, shows up at one of those two samples. A short dropout in the middle of a qualification is the key corner case: a design that paused the count instead of restarting it would declare carrier about ten ticks early. Gaps in the tick enable would expose a counter that ran on raw clocks. A mode switch made while carrier is held would catch a design that carried the old count or state into the new mode. The power-down and idle cases check that a steadily asserted raw flag cannot qualify, and that counting starts again from zero once the block is released.

// File: rtl/cdq_pkg.sv
package cdq_pkg;

   typedef enum logic [1:0] {
      MD_FSK  = 2'b00,
      MD_DTMF = 2'b01,
      MD_CPT  = 2'b10,
      MD_IDLE = 2'b11
   } cdq_mode_e;

   typedef enum logic {
      ST_QUIET  = 1'b0,
      ST_LOCKED = 1'b1
   } cdq_state_e;

   // longest qualification time in ticks, used for width checks
   localparam int unsigned CDQ_MAX_DELAY = 450;

   // qualification (on) time in ticks
   function automatic int unsigned cdq_on_ticks(input cdq_mode_e md,
                                                input logic [1:0] fsel,
                                                input logic [1:0] dsel);
      int unsigned r;
      r = 0;
      unique case (md)
         MD_FSK: begin
            unique case (fsel)
               2'b00: r = 450;
               2'b01: r = 15;
               2'b10: r = 15;
               default: r = 75;
            endcase
         end
         MD_DTMF: begin
            unique case (dsel)
               2'b01: r = 35;
               2'b10: r = 45;
               default: r = 30;
            endcase
         end
         MD_CPT:  r = 10;
         default: r = 0;
      endcase
      return r;
   endfunction

   // release (off) time in ticks
   function automatic int unsigned cdq_off_ticks(input cdq_mode_e md,
                                                 input logic [1:0] fsel,
                                                 input logic [1:0] dsel);
      int unsigned r;
      r = 0;
      unique case (md)
         MD_FSK: begin
            unique case (fsel)
               2'b00: r = 30;
               2'b01: r = 30;
               2'b10: r = 15;
               default: r = 10;
            endcase
         end
         MD_DTMF: begin
            unique case (dsel)
               2'b01: r = 35;
               default: r = 25;
            endcase
         end
         MD_CPT:  r = 25;
         default: r = 0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cdq_tick_gen.sv
module cdq_tick_gen #(
   parameter int unsigned TICK_DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic base_en,
   output logic tick_eff
);
   localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   if (TICK_DIV < 1) begin : g_bad_div
      $error("cdq_tick_gen: TICK_DIV must be at least 1");
   end

   if (TICK_DIV == 1) begin : g_direct
      assign tick_eff = base_en;
   end else begin : g_prescale
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pcnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pcnt <= '0;
         end else if (base_en) begin
            if (pcnt == LAST) pcnt <= '0;
            else              pcnt <= pcnt + 1'b1;
         end
      end

      assign tick_eff = base_en && (pcnt == LAST);
   end

endmodule

// File: rtl/cdq_delay_lut.sv
module cdq_delay_lut
   import cdq_pkg::*;
#(
   parameter int unsigned CNT_W = 9
) (
   input  cdq_mode_e        mode,
   input  logic [1:0]       fsk_sel,
   input  logic [1:0]       dtmf_sel,
   output logic [CNT_W-1:0] on_lim,
   output logic [CNT_W-1:0] off_lim
);
   if (CDQ_MAX_DELAY > (2**CNT_W) - 1) begin : g_bad_width
      $error("cdq_delay_lut: CNT_W too narrow for the longest delay");
   end

   always_comb begin
      on_lim  = CNT_W'(cdq_on_ticks(mode, fsk_sel, dtmf_sel));
      off_lim = CNT_W'(cdq_off_ticks(mode, fsk_sel, dtmf_sel));
   end

endmodule

// File: rtl/cdq_qualifier.sv
module cdq_qualifier
   import cdq_pkg::*;
#(
   parameter int unsigned CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             raw,
   input  logic             clear,
   input  logic [CNT_W-1:0] on_lim,
   input  logic [CNT_W-1:0] off_lim,
   output logic             locked
);
   cdq_state_e       st;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;
   logic             opposite;
   logic [CNT_W-1:0] lim;

   assign cnt_inc  = cnt + 1'b1;
   assign opposite = (st == ST_QUIET) ? !raw : raw;
   assign lim      = (st == ST_QUIET) ? on_lim : off_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_QUIET;
         cnt <= '0;
      end else if (clear) begin
         st  <= ST_QUIET;
         cnt <= '0;
      end else if (opposite) begin
         cnt <= '0;
      end else if (tick) begin
         if (cnt_inc >= lim) begin
            st  <= (st == ST_QUIET) ? ST_LOCKED : ST_QUIET;
            cnt <= '0;
         end else begin
            cnt <= cnt_inc;
         end
      end
   end

   assign locked = (st == ST_LOCKED);

endmodule

// File: rtl/cdq_out_gate.sv
module cdq_out_gate
   import cdq_pkg::*;
#(
   parameter int unsigned CODE_W = 4
) (
   input  logic              locked,
   input  cdq_mode_e         mode,
   input  logic              pd_any,
   input  logic              rx_bit,
   input  logic [CODE_W-1:0] code,
   output logic              cd_n,
   output logic              rxd_out,
   output logic [CODE_W-1:0] dig_out,
   output logic              dig_en
);
   always_comb begin
      cd_n    = !locked;
      rxd_out = locked ? rx_bit : 1'b1;
      dig_en  = !pd_any;
      if (locked && (mode == MD_DTMF) && !pd_any) dig_out = code;
      else                                         dig_out = '0;
   end

endmodule

// File: rtl/cdq_timer.sv
module cdq_timer
   import cdq_pkg::*;
#(
   parameter int unsigned CNT_W    = 9,
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned TICK_DIV = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_ms,
   input  logic              raw_det,
   input  logic [1:0]        mode,
   input  logic [1:0]        fsk_sel,
   input  logic [1:0]        dtmf_sel,
   input  logic              rx_bit,
   input  logic [CODE_W-1:0] dtmf_code,
   input  logic              pd1,
   input  logic              pd2,
   output logic              cd_n,
   output logic              rxd_out,
   output logic [CODE_W-1:0] dig_out,
   output logic              dig_en
);
   if (CODE_W < 1) begin : g_bad_code
      $error("cdq_timer: CODE_W must be positive");
   end

   cdq_mode_e        mode_e;
   cdq_mode_e        mode_q;
   logic             tick_eff;
   logic             pd_any;
   logic             mode_chg;
   logic             clear;
   logic             locked;
   logic [CNT_W-1:0] on_lim;
   logic [CNT_W-1:0] off_lim;

   assign mode_e   = cdq_mode_e'(mode);
   assign pd_any   = pd1 | pd2;
   assign mode_chg = (mode_e != mode_q);
   assign clear    = pd_any | mode_chg | (mode_e == MD_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MD_IDLE;
      else        mode_q <= mode_e;
   end

   cdq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .base_en  (tick_ms),
      .tick_eff (tick_eff)
   );

   cdq_delay_lut #(.CNT_W(CNT_W)) u_lut (
      .mode     (mode_e),
      .fsk_sel  (fsk_sel),
      .dtmf_sel (dtmf_sel),
      .on_lim   (on_lim),
      .off_lim  (off_lim)
   );

   cdq_qualifier #(.CNT_W(CNT_W)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_eff),
      .raw     (raw_det),
      .clear   (clear),
      .on_lim  (on_lim),
      .off_lim (off_lim),
      .locked  (locked)
   );

   cdq_out_gate #(.CODE_W(CODE_W)) u_gate (
      .locked  (locked),
      .mode    (mode_e),
      .pd_any  (pd_any),
      .rx_bit  (rx_bit),
      .code    (dtmf_code),
      .cd_n    (cd_n),
      .rxd_out (rxd_out),
      .dig_out (dig_out),
      .dig_en  (dig_en)
   );

endmodule

// File: rtl/cdq_timer_chk.sv
module cdq_timer_chk #(
   parameter int unsigned CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_eff,
   input logic              raw_det,
   input logic [1:0]        mode,
   input logic [1:0]        mode_q,
   input logic              pd1,
   input logic              pd2,
   input logic              cd_n,
   input logic              rxd_out,
   input logic [CODE_W-1:0] dig_out,
   input logic              dig_en
);
   // carrier is only declared on a counted tick with the raw flag high
   assert_lock_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cd_n) |-> $past(raw_det && tick_eff));

   // release needs a low raw flag, a power-down, or a mode change
   assert_release_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cd_n) |-> $past(!raw_det || pd1 || pd2 || (mode != mode_q) || (mode == 2'b11)));

   assert_rxd_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cd_n |-> rxd_out);

   assert_digit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cd_n |-> (dig_out == '0));

   assert_pd_pads_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pd1 || pd2) |-> !dig_en);

   assert_pd_drops_cd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pd1 || pd2) |=> cd_n);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11) |=> cd_n);

   assert_mode_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != mode_q) |=> cd_n);

endmodule

bind cdq_timer cdq_timer_chk #(.CODE_W(CODE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_eff (tick_eff),
   .raw_det  (raw_det),
   .mode     (mode),
   .mode_q   (mode_q),
   .pd1      (pd1),
   .pd2      (pd2),
   .cd_n     (cd_n),
   .rxd_out  (rxd_out),
   .dig_out  (dig_out),
   .dig_en   (dig_en)
);

// File: tb/sim_cdq_timer.sv
`timescale 1ns/1ps
module sim_cdq_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_ms = 1'b1;
   logic       raw_det = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [1:0] fsk_sel = 2'b00;
   logic [1:0] dtmf_sel = 2'b00;
   logic       rx_bit = 1'b0;
   logic [3:0] dtmf_code = 4'h0;
   logic       pd1 = 1'b0;
   logic       pd2 = 1'b0;
   logic       cd_n, rxd_out, dig_en;
   logic [3:0] dig_out;
   logic       cd_n_d3, rxd_d3, en_d3;
   logic [3:0] dig_d3;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   cdq_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .raw_det(raw_det),
      .mode(mode), .fsk_sel(fsk_sel), .dtmf_sel(dtmf_sel), .rx_bit(rx_bit),
      .dtmf_code(dtmf_code), .pd1(pd1), .pd2(pd2),
      .cd_n(cd_n), .rxd_out(rxd_out), .dig_out(dig_out), .dig_en(dig_en)
   );

   cdq_timer #(.TICK_DIV(3)) u1 (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .raw_det(raw_det),
      .mode(mode), .fsk_sel(fsk_sel), .dtmf_sel(dtmf_sel), .rx_bit(rx_bit),
      .dtmf_code(dtmf_code), .pd1(pd1), .pd2(pd2),
      .cd_n(cd_n_d3), .rxd_out(rxd_d3), .dig_out(dig_d3), .dig_en(en_d3)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic setup(input logic [1:0] m, input logic [1:0] fs, input logic [1:0] ds);
      raw_det = 1'b0; tick_ms = 1'b1;
      mode = m; fsk_sel = fs; dtmf_sel = ds;
      step(3);
   endtask

   task automatic qualify(input string req, input int on_t, input int off_t);
      raw_det = 1'b1;
      step(on_t - 1); chk({req, " before qualify"}, cd_n, 1);
      step(1);        chk({req, " qualify"}, cd_n, 0);
      raw_det = 1'b0;
      step(off_t - 1); chk({req, " before release"}, cd_n, 0);
      step(1);         chk({req, " release"}, cd_n, 1);
   endtask

   task automatic t_reset;
      chk("R1 cd_n", cd_n, 1);
      chk("R1 rxd_out", rxd_out, 1);
      chk("R1 dig_out", dig_out, 0);
   endtask

   task automatic t_fsk;
      setup(2'b00, 2'b00, 2'b00); qualify("R2 R3 fsk sel00", 450, 30);
      setup(2'b00, 2'b01, 2'b00); qualify("R2 R3 fsk sel01", 15, 30);
      setup(2'b00, 2'b10, 2'b00); qualify("R2 R3 fsk sel10", 15, 15);
      setup(2'b00, 2'b11, 2'b00); qualify("R2 R3 fsk sel11", 75, 10);
   endtask

   task automatic t_dtmf;
      setup(2'b01, 2'b00, 2'b00); qualify("R4 dtmf sel00", 30, 25);
      setup(2'b01, 2'b00, 2'b01); qualify("R4 dtmf sel01", 35, 35);
      setup(2'b01, 2'b00, 2'b10); qualify("R4 dtmf sel10", 45, 25);
      setup(2'b01, 2'b00, 2'b11); qualify("R4 dtmf sel11", 30, 25);
   endtask

   task automatic t_cpt;
      setup(2'b10, 2'b00, 2'b10); qualify("R5 cpt", 10, 25);
      setup(2'b10, 2'b11, 2'b01); qualify("R5 cpt other sels", 10, 25);
   endtask

   task automatic t_restart;
      setup(2'b00, 2'b01, 2'b00);
      raw_det = 1'b1; step(10);
      raw_det = 1'b0; step(1);
      raw_det = 1'b1;
      step(14); chk("R6 restart after dropout", cd_n, 1);
      step(1);  chk("R6 qualify after restart", cd_n, 0);
      // release with a glitch high in the middle of the off window
      raw_det = 1'b0; step(20);
      raw_det = 1'b1; step(1);
      raw_det = 1'b0;
      step(29); chk("R6 release restart", cd_n, 0);
      step(1);  chk("R6 release after restart", cd_n, 1);
      // ticks gated
      tick_ms = 1'b0; raw_det = 1'b1;
      step(50); chk("R6 no tick no count", cd_n, 1);
      for (int i = 0; i < 14; i++) begin
         tick_ms = 1'b1; step(1);
         tick_ms = 1'b0; step(1);
      end
      chk("R6 sparse ticks 14", cd_n, 1);
      tick_ms = 1'b1; step(1);
      chk("R6 sparse ticks 15", cd_n, 0);
      raw_det = 1'b0; step(30);
   endtask

   task automatic t_rxd;
      setup(2'b00, 2'b01, 2'b00);
      rx_bit = 1'b0; step(1);
      chk("R7 clamp without carrier", rxd_out, 1);
      raw_det = 1'b1; step(15);
      chk("R7 carrier present", cd_n, 0);
      rx_bit = 1'b0; step(1); chk("R7 pass 0", rxd_out, 0);
      rx_bit = 1'b1; step(1); chk("R7 pass 1", rxd_out, 1);
      rx_bit = 1'b0; raw_det = 1'b0; step(30);
      chk("R7 clamp after release", rxd_out, 1);
   endtask

   task automatic t_digit;
      setup(2'b01, 2'b00, 2'b00);
      dtmf_code = 4'b1010; raw_det = 1'b1;
      step(29); chk("R8 digit held before carrier", dig_out, 0);
      step(1);  chk("R8 digit passes", dig_out, 4'b1010);
      dtmf_code = 4'b0011; step(1);
      chk("R8 digit follows code", dig_out, 4'b0011);
      raw_det = 1'b0; step(25);
      chk("R8 digit zero after release", dig_out, 0);
      setup(2'b00, 2'b01, 2'b00);
      raw_det = 1'b1; step(15);
      chk("R8 fsk carrier", cd_n, 0);
      chk("R8 no digit in fsk", dig_out, 0);
      raw_det = 1'b0; step(30);
   endtask

   task automatic t_pd;
      setup(2'b01, 2'b00, 2'b00);
      dtmf_code = 4'b0110; raw_det = 1'b1; step(30);
      chk("R9 locked before pd", cd_n, 0);
      chk("R9 pads on", dig_en, 1);
      pd1 = 1'b1; step(1);
      chk("R9 pd1 drops cd", cd_n, 1);
      chk("R9 pd1 pads off", dig_en, 0);
      pd1 = 1'b0; pd2 = 1'b1; step(100);
      chk("R9 pd2 no qualify", cd_n, 1);
      chk("R9 pd2 pads off", dig_en, 0);
      pd2 = 1'b0;
      step(29); chk("R9 count from zero", cd_n, 1);
      step(1);  chk("R9 qualify after pd", cd_n, 0);
      chk("R9 pads back", dig_en, 1);
      raw_det = 1'b0; step(25);
   endtask

   task automatic t_idle;
      setup(2'b11, 2'b01, 2'b00);
      raw_det = 1'b1; step(500);
      chk("R10 idle ignores raw", cd_n, 1);
      raw_det = 1'b0; step(2);
   endtask

   task automatic t_mode_change;
      setup(2'b00, 2'b01, 2'b00);
      raw_det = 1'b1; step(15);
      chk("R11 fsk locked", cd_n, 0);
      mode = 2'b10;
      step(1);  chk("R11 drop on change", cd_n, 1);
      step(9);  chk("R11 new count pending", cd_n, 1);
      step(1);  chk("R11 new mode qualify", cd_n, 0);
      raw_det = 1'b0; step(25);
   endtask

   task automatic t_prescale;
      raw_det = 1'b0; mode = 2'b10; tick_ms = 1'b1;
      rst_n = 1'b0; step(2);
      rst_n = 1'b1; step(3);
      raw_det = 1'b1;
      step(10); chk("R12 undivided qualifies", cd_n, 0);
      step(17); chk("R12 divided not yet", cd_n_d3, 1);
      step(3);  chk("R12 divided qualifies", cd_n_d3, 0);
      raw_det = 1'b0; step(80);
      chk("R12 divided release", cd_n_d3, 1);
   endtask

   initial begin
      step(3);
      t_reset();
      rst_n = 1'b1;
      step(2);
      t_fsk();
      t_dtmf();
      t_cpt();
      t_restart();
      t_rxd();
      t_digit();
      t_pd();
      t_idle();
      t_mode_change();
      t_prescale();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule